// File: doc/BRIEF.md
# Manchester Line Encoder with Sync Preamble

This block turns a serial NRZ stream into a complementary pair of biphase (Manchester) line outputs. A single system clock drives it. One free-running counter divides that clock into bit periods and marks the half-bit points. The block drives a bit clock output. The external data source watches the falling edges of that clock and presents its next NRZ bit after each one.

The clear-to-send input gates transmission. While it is high, the line sits at its idle level. Once it is low, the block waits for the next bit boundary and then sends a fixed preamble of eight zero bits. A three-bit command sync follows. The sync has no mid-bit transition, so a receiver can tell it apart from data. After the sync, the sampled data bits go out back to back, with no framing, for as long as clear-to-send stays low. When clear-to-send is raised, the bit already on the line is completed, and the outputs go idle at the next boundary.

The primary line output carries the inverted biphase waveform, and the second output is its complement. Both outputs sit high while idle.

Top module: `manchester_tx`

## Requirements
- R1: After reset, and whenever no transmission is in progress, `man_o` and `man_n_o` are both 1 and `bit_clk_o` is 0.
- R2: A transmission begins only at a bit boundary, 1 to 2 bit periods after `cts_i` goes low. It opens with eight preamble bits, and on `man_o` each of them is 1 in the first half and 0 in the second half.
- R3: The preamble is followed directly by a three-bit command sync, which on `man_o` is 0 for three half-bits and then 1 for three half-bits.
- R4: After the sync, each data bit d is sent on `man_o` as ~d in the first half and d in the second half, so that a 0 falls at mid-bit and a 1 rises at mid-bit.
- R5: While a transmission is in progress, `man_n_o` is always the complement of `man_o`.
- R6: `bit_clk_o` is 0 through the preamble and the first two sync bits. From the third sync bit onward it is 1 in the first half and 0 in the second half of every bit.
- R7: `nrz_i` is sampled at each falling edge of `bit_clk_o`. The value sampled during a bit is sent in the next bit, so the sample taken in the last sync bit becomes the first data bit.
- R8: Data bits follow one another with no gap for as long as `cts_i` stays low.
- R9: If `cts_i` is 1 in any cycle of a bit, the current bit is completed and the outputs are idle from the next boundary. The bit sampled during that final bit is not sent.
- R10: A one-cycle high pulse on `cts_i` ends the transmission after the current bit, leaves the line idle for exactly one bit period, and then starts a new preamble.
- R11: A bit period lasts exactly `BIT_CLKS` system clocks, and the falling edges of `bit_clk_o` are spaced by that count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cts_i | input | 1 | Clear-to-send; high holds the line idle, low enables transmission |
| nrz_i | input | 1 | Serial NRZ data, sampled at falling edges of `bit_clk_o` |
| bit_clk_o | output | 1 | 1x bit clock for the data source, active only during the last sync bit and the data bits |
| man_o | output | 1 | Inverted biphase line output, idle high |
| man_n_o | output | 1 | Complement of `man_o` while transmitting, idle high |

## Verification
The assertions assume that `cts_i` and `nrz_i` are synchronous to `clk` and change only away from its rising edge. They also assume that `BIT_CLKS` is even and at least 4, so that the half-bit and end-of-bit points never fall in the same cycle. The bench changes both inputs only on falling clock edges. It presents each new NRZ bit in the cycle after a falling edge of `bit_clk_o`, which keeps every bit stable through the next sampling edge. It raises `cts_i` only just after a falling edge of `bit_clk_o`, so the bit in flight at that moment is known when the expected idle period is queued.

// File: rtl/mfe_pkg.sv
package mfe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_SYNC = 2'd2,
    ST_DATA = 2'd3
  } tx_state_t;

  localparam int unsigned SYNC_BITS = 3;

endpackage

// File: rtl/mfe_timebase.sv
module mfe_timebase #(
  parameter int unsigned BIT_CLKS = 16,
  localparam int unsigned CW   = $clog2(BIT_CLKS),
  localparam int unsigned HALF = BIT_CLKS / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o,
  output logic          mid_o,
  output logic          end_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == CW'(BIT_CLKS - 1)) cnt_d = '0;
    else                            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign mid_o = (cnt_q == CW'(HALF));
  assign end_o = (cnt_q == CW'(BIT_CLKS - 1));

  // R11: the sample point and the bit boundary are distinct cycles
  assert_tick_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mid_o |-> !end_o);

  // R11: a boundary is followed by a full bit before the next one
  assert_bound_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !end_o);

endmodule

// File: rtl/mfe_sequencer.sv
module mfe_sequencer
  import mfe_pkg::*;
#(
  parameter int unsigned PRE_BITS = 8,
  localparam int unsigned IW = (PRE_BITS > 4) ? $clog2(PRE_BITS) : 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cts_i,
  input  logic          end_i,
  output tx_state_t     state_o,
  output logic [IW-1:0] idx_o
);

  tx_state_t     state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          halt_q, halt_d;
  logic          stop;

  assign stop = halt_q | cts_i;

  always_comb begin
    halt_d  = end_i ? 1'b0 : (halt_q | cts_i);
    state_d = state_q;
    idx_d   = idx_q;
    if (end_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!stop) begin
            state_d = ST_PRE;
            idx_d   = '0;
          end
        end
        ST_PRE: begin
          if (stop) begin
            state_d = ST_IDLE;
          end else if (idx_q == IW'(PRE_BITS - 1)) begin
            state_d = ST_SYNC;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_SYNC: begin
          if (stop) begin
            state_d = ST_IDLE;
          end else if (idx_q == IW'(SYNC_BITS - 1)) begin
            state_d = ST_DATA;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (stop) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      halt_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      halt_q  <= halt_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;

  // R2: the state moves only at bit boundaries
  assert_state_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state_q) |-> $past(end_i));

  // R9: a clear-to-send seen during a bit ends the transmission at its boundary
  assert_stop_after_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && cts_i) |=> (state_q == ST_IDLE));

  // R2: the preamble always opens a transmission
  assert_open_with_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_IDLE && state_q != ST_IDLE) |-> (state_q == ST_PRE));

endmodule

// File: rtl/mfe_shaper.sv
module mfe_shaper
  import mfe_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 16,
  parameter int unsigned IW       = 3,
  localparam int unsigned CW   = $clog2(BIT_CLKS),
  localparam int unsigned HALF = BIT_CLKS / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tx_state_t     state_i,
  input  logic [IW-1:0] idx_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          mid_i,
  input  logic          end_i,
  input  logic          nrz_i,
  output logic          man_o,
  output logic          man_n_o,
  output logic          bit_clk_o
);

  logic first_half;
  logic ck_en;
  logic active;
  logic line_inv;
  logic [IW:0] sync_half;

  logic smp_q, smp_d;
  logic cur_q, cur_d;
  logic man_q, man_d;
  logic mann_q, mann_d;
  logic bck_q, bck_d;

  assign first_half = (cnt_i < CW'(HALF));
  assign active     = (state_i != ST_IDLE);
  assign ck_en      = (state_i == ST_DATA) ||
                      ((state_i == ST_SYNC) && (idx_i == IW'(SYNC_BITS - 1)));
  assign sync_half  = {idx_i, 1'b0} + {{IW{1'b0}}, ~first_half};

  // level of the inverted line for the current half-bit
  always_comb begin
    unique case (state_i)
      ST_PRE:  line_inv = first_half;
      ST_SYNC: line_inv = (sync_half >= (IW+1)'(SYNC_BITS));
      ST_DATA: line_inv = first_half ? ~cur_q : cur_q;
      default: line_inv = 1'b1;
    endcase
  end

  always_comb begin
    smp_d  = (mid_i && ck_en) ? nrz_i : smp_q;
    cur_d  = end_i ? smp_q : cur_q;
    man_d  = active ? line_inv  : 1'b1;
    mann_d = active ? ~line_inv : 1'b1;
    bck_d  = ck_en & first_half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      cur_q  <= 1'b0;
      man_q  <= 1'b1;
      mann_q <= 1'b1;
      bck_q  <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      cur_q  <= cur_d;
      man_q  <= man_d;
      mann_q <= mann_d;
      bck_q  <= bck_d;
    end
  end

  assign man_o     = man_q;
  assign man_n_o   = mann_q;
  assign bit_clk_o = bck_q;

  // R4: every preamble and data bit changes level at mid-bit
  assert_mid_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_i == CW'(HALF)) && (state_i == ST_DATA || state_i == ST_PRE))
      |=> (man_q != $past(man_q)));

  // R6: no bit clock while the preamble is on the line
  assert_quiet_preamble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_PRE) |=> !bck_q);

endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import mfe_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 16,
  parameter int unsigned PRE_BITS = 8,
  localparam int unsigned CW = $clog2(BIT_CLKS),
  localparam int unsigned IW = (PRE_BITS > 4) ? $clog2(PRE_BITS) : 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_i,
  input  logic nrz_i,
  output logic bit_clk_o,
  output logic man_o,
  output logic man_n_o
);

  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic [CW-1:0] cnt;
  logic          mid_tick;
  logic          end_tick;
  tx_state_t     state;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  mfe_timebase #(.BIT_CLKS(BIT_CLKS)) u_timebase (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cnt_o (cnt),
    .mid_o (mid_tick),
    .end_o (end_tick)
  );

  mfe_sequencer #(.PRE_BITS(PRE_BITS)) u_sequencer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cts_i   (cts_i),
    .end_i   (end_tick),
    .state_o (state),
    .idx_o   (idx)
  );

  mfe_shaper #(.BIT_CLKS(BIT_CLKS), .IW(IW)) u_shaper (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .state_i   (state),
    .idx_i     (idx),
    .cnt_i     (cnt),
    .mid_i     (mid_tick),
    .end_i     (end_tick),
    .nrz_i     (nrz_i),
    .man_o     (man_o),
    .man_n_o   (man_n_o),
    .bit_clk_o (bit_clk_o)
  );

  // R5: outputs are complementary whenever the bit clock runs
  assert_complement_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_clk_o |-> (man_o != man_n_o));

  // R1: an idle line carries no bit clock
  assert_idle_clk_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (man_o && man_n_o) |-> !bit_clk_o);

endmodule

// File: tb/manchester_tx_test.sv
module manchester_tx_test;

  localparam int BIT  = 16;
  localparam int HALF = BIT / 2;

  typedef struct packed {
    logic       last;
    logic [2:0] kind;
    logic       lvl;
    logic       ck;
  } item_t;

  logic clk;
  logic rst_n;
  logic cts_i;
  logic nrz_i;
  logic bit_clk_o;
  logic man_o;
  logic man_n_o;

  int checks;
  int fails;
  int cyc;
  int fall_cyc;
  item_t exp_q[$];

  manchester_tx #(.BIT_CLKS(BIT), .PRE_BITS(8)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cts_i     (cts_i),
    .nrz_i     (nrz_i),
    .bit_clk_o (bit_clk_o),
    .man_o     (man_o),
    .man_n_o   (man_n_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic string tag_of(logic [2:0] k);
    case (k)
      3'd0:    return "R2 preamble";
      3'd1:    return "R3 sync";
      3'd2:    return "R4 R7 R8 data";
      3'd3:    return "R9 stop idle";
      default: return "R10 pulse idle";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic item_t mk(logic last, logic [2:0] kind, logic lvl, logic ck);
    item_t it;
    it.last = last; it.kind = kind; it.lvl = lvl; it.ck = ck;
    return it;
  endfunction

  function automatic logic gen(int pat, int i);
    case (pat)
      1:       return 1'b1;
      2:       return logic'(i % 2);
      3:       return 1'b0;
      default: return logic'($urandom_range(0, 1));
    endcase
  endfunction

  task automatic push_header();
    for (int b = 0; b < 8; b++) begin
      exp_q.push_back(mk(1'b0, 3'd0, 1'b1, 1'b0));
      exp_q.push_back(mk(1'b0, 3'd0, 1'b0, 1'b0));
    end
    for (int h = 0; h < 6; h++)
      exp_q.push_back(mk(1'b0, 3'd1, (h >= 3), (h == 4)));
  endtask

  task automatic push_idle(int n, logic [2:0] kind);
    for (int h = 0; h < n; h++)
      exp_q.push_back(mk(h == n - 1, kind, 1'b1, 1'b0));
  endtask

  // driver: one transmission of nbits data bits, then a stop
  task automatic run_session(int nbits, int pat, bit pulse_stop, bit lower);
    logic cur;
    int   last_fall;
    cur = gen(pat, 0);
    @(negedge clk);
    nrz_i = cur;
    push_header();
    if (lower) begin
      cts_i    = 1'b0;
      fall_cyc = cyc;
    end
    last_fall = -1;
    for (int i = 0; i <= nbits; i++) begin
      @(negedge bit_clk_o);
      @(negedge clk);
      if (last_fall >= 0)
        check((cyc - last_fall) == BIT, "R11 bit clock spacing", cyc - last_fall, BIT);
      last_fall = cyc;
      if (i < nbits) begin
        exp_q.push_back(mk(1'b0, 3'd2, ~cur, 1'b1));
        exp_q.push_back(mk(1'b0, 3'd2, cur, 1'b0));
        cur   = gen(pat, i + 1);
        nrz_i = cur;
      end else if (pulse_stop) begin
        cts_i = 1'b1;
        push_idle(2, 3'd4);
        @(negedge clk);
        cts_i    = 1'b0;
        fall_cyc = cyc;
      end else begin
        cts_i = 1'b1;
        push_idle(4, 3'd3);
      end
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2 * BIT) @(negedge clk);
  endtask

  // monitor: locks on the start of each transmission and compares half-bits
  initial begin
    item_t it;
    bit    ok;
    forever begin
      @(negedge clk);
      if (rst_n && (man_o != man_n_o)) begin
        check(((cyc - fall_cyc) >= BIT) && ((cyc - fall_cyc) <= 2 * BIT + 4),
              "R2 start latency", cyc - fall_cyc, BIT);
        repeat (HALF / 2) @(negedge clk);
        forever begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected activity", int'(man_o), 1);
            break;
          end
          it = exp_q.pop_front();
          if (it.kind >= 3'd3)
            ok = (man_o == 1'b1) && (man_n_o == 1'b1) && (bit_clk_o == 1'b0);
          else
            ok = (man_o == it.lvl) && (man_n_o == ~it.lvl) && (bit_clk_o == it.ck);
          check(ok, {tag_of(it.kind), " R5 R6"},
                {man_o, man_n_o, bit_clk_o}, {it.lvl, (it.kind >= 3'd3) ? 1'b1 : ~it.lvl, it.ck});
          if (it.last) break;
          repeat (HALF) @(negedge clk);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    checks   = 0;
    fails    = 0;
    cyc      = 0;
    fall_cyc = 0;
    rst_n    = 1'b0;
    cts_i    = 1'b1;
    nrz_i    = 1'b0;
    repeat (5) @(negedge clk);
    check((man_o == 1'b1) && (man_n_o == 1'b1) && (bit_clk_o == 1'b0),
          "R1 in reset", {man_o, man_n_o, bit_clk_o}, 3'b110);
    rst_n = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check((man_o == 1'b1) && (man_n_o == 1'b1) && (bit_clk_o == 1'b0),
            "R1 held idle", {man_o, man_n_o, bit_clk_o}, 3'b110);
      repeat (BIT - 3) @(negedge clk);
    end

    run_session(12, 0, 1'b0, 1'b1);
    drain();
    check((man_o == 1'b1) && (man_n_o == 1'b1) && (bit_clk_o == 1'b0),
          "R9 idle after stop", {man_o, man_n_o, bit_clk_o}, 3'b110);

    run_session(10, 1, 1'b1, 1'b1);
    run_session(8, 2, 1'b0, 1'b0);
    drain();

    repeat (5) @(negedge clk);
    run_session(9, 3, 1'b0, 1'b1);
    drain();

    run_session(20, 0, 1'b0, 1'b1);
    drain();
    check((man_o == 1'b1) && (man_n_o == 1'b1) && (bit_clk_o == 1'b0),
          "R1 final idle", {man_o, man_n_o, bit_clk_o}, 3'b110);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule